// File: doc/BRIEF.md
# Three-Phase Complementary PWM with Staged Duty Update

This block generates three complementary PWM phase pairs from a triangular carrier. New duty and timing values do not reach the comparators directly. Each one passes through three stages: a software-visible buffer, a temporary stage and an active compare stage. Software writes the buffers in any order. It writes the third phase's duty buffer last, and that write arms a transfer. All five staged values (three duties, carrier peak, dead time) then move into the temporary stage together. That move waits until the carrier is outside the windows around its crest and trough. The temporary values later become active at the crest or at the trough, as a mode pin selects.

During the carrier window that carries no temporary load, each phase compares the carrier against both its active duty and its newer temporary duty. An edge that the new value requests is therefore not lost while the old value is still in force. Every transition of a phase inserts a dead band in which neither side of the pair is driven. Each side has its own active-level pin.

Top module: `cpwm_staged_update`

## Requirements
- R1: Register writes use a valid/ready channel whose ready is always high. The buffer addresses are 0, 1 and 2 for the duty of phases 0 to 2, 3 for the carrier peak P and 4 for the dead time D. Reading an address returns that buffer at once. Reading address 8+k returns active stage k. Other addresses read 0 and ignore writes. A write to any buffer other than address 2 changes no active value and arms nothing.
- R2: A write to address 2 arms the transfer. An armed transfer that cannot complete at once is shown on `xfer_pend`.
- R3: When the transfer is armed while `ival` is 0, all five buffers (including the value being written) copy into the temporary stage on that edge, and `xfer_pend` stays 0.
- R4: When the transfer is armed while `ival` is 1 or 2, `xfer_pend` rises and stays 1 until that interval's last cycle. The copy happens on that cycle's edge, so `xfer_pend` is 0 once `ival` returns to 0.
- R5: With `xfer_at_crest`=0, the active stage takes the temporary stage at the trough (carrier down-counting at 0). With `xfer_at_crest`=1, it takes it at the crest (carrier up-counting at P). At no other time does the active stage change.
- R6: The carrier counts 0 up to the active P and back down, for a period of 2P cycles. `ival` reads 1 (window before the crest) while the carrier is counting up and at least P−D, which lasts D+1 cycles. It reads 2 (window before the trough) while the carrier is counting down and at most D. It reads 0 otherwise and never reads 3.
- R7: In the window before the crest (trough mode) or the window before the trough (crest mode), a phase also matches on its temporary duty as well as its active duty.
- R8: A match while the carrier counts up moves a phase to its positive side, and a match while it counts down moves it to its negative side. Each move blanks both sides for D cycles. With duty d, the positive side is driven for 2(P−d)−D cycles and the negative side for 2d−D cycles.
- R9: A driven side takes the level on `lvl_p` / `lvl_n`, and an undriven side takes the opposite level.
- R10: The two sides of a phase are never driven together.
- R11: Buffer writes made while a transfer is pending are the values that the pending copy takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | AW | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | CW | Read data (combinational) |
| xfer_at_crest | input | 1 | 1: activate at crest, 0: at trough |
| lvl_p | input | 1 | Driven level of positive sides |
| lvl_n | input | 1 | Driven level of negative sides |
| pwm_p | output | 3 | Positive-side outputs, one per phase |
| pwm_n | output | 3 | Negative-side outputs, one per phase |
| ival | output | 2 | Carrier interval: 0 open, 1 pre-crest, 2 pre-trough |
| xfer_pend | output | 1 | Armed transfer waiting for its interval to end |

## Verification
The staged path is tried by arming in the open interval while the carrier counts up, which must copy at once, and by arming inside the pre-crest window, which must defer. In the deferred case a further buffer write arrives while the transfer is pending, which shows whether the copy samples the buffers late or early. Activation is run once in each mode, with the active values read back just before and just after the chosen point. This separates a crest load from a trough load. A duty value placed inside the dual-compare window, after an active duty that never matches, shows whether the temporary comparator really takes part. Pulse, dead-band and interval widths measured on two different peak and dead-time settings confirm that the timing values flow through the same pipeline.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  localparam int NPH = 3;
  typedef enum logic [1:0] {
    IV_OPEN = 2'd0,
    IV_PRE_CREST = 2'd1,
    IV_PRE_TROUGH = 2'd2
  } ival_e;
endpackage

// File: rtl/cpwm_carrier.sv
`timescale 1ns/1ps
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] peak,
  input  logic [CW-1:0] dead,
  output logic [CW-1:0] ct,
  output logic          up,
  output ival_e         iv,
  output logic          crest_ev,
  output logic          trough_ev
);
  logic [CW:0] ct_plus_dead;

  assign ct_plus_dead = {1'b0, ct} + {1'b0, dead};
  assign crest_ev  = up && (ct >= peak);
  assign trough_ev = !up && (ct == '0);

  always_comb begin
    if (up && (ct_plus_dead >= {1'b0, peak})) iv = IV_PRE_CREST;
    else if (!up && (ct <= dead))             iv = IV_PRE_TROUGH;
    else                                      iv = IV_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ct <= '0;
      up <= 1'b1;
    end else if (crest_ev) begin
      up <= 1'b0;
      ct <= (ct == '0) ? '0 : ct - 1'b1;
    end else if (trough_ev) begin
      up <= 1'b1;
      ct <= ct + 1'b1;
    end else begin
      ct <= up ? ct + 1'b1 : ct - 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_stage.sv
`timescale 1ns/1ps
module cpwm_stage
  import cpwm_pkg::*;
#(
  parameter int CW       = 16,
  parameter int AW       = 4,
  parameter int RST_PEAK = 100,
  parameter int RST_DEAD = 4,
  parameter int RST_DUTY = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [CW-1:0]           rd_data,
  input  ival_e                   iv,
  input  logic                    crest_ev,
  input  logic                    trough_ev,
  input  logic                    at_crest,
  output logic [NPH-1:0][CW-1:0]  tmp_duty,
  output logic [NPH+1:0][CW-1:0]  cmp_q,
  output logic                    pend,
  output logic                    cmp_ld
);
  localparam int NV       = NPH + 2;
  localparam int ARM_IDX  = NPH - 1;
  localparam int CMP_BASE = 1 << (AW - 1);

  function automatic logic [CW-1:0] rst_val(input int i);
    if (i < NPH)       return CW'(RST_DUTY);
    else if (i == NPH) return CW'(RST_PEAK);
    else               return CW'(RST_DEAD);
  endfunction

  logic [NV-1:0][CW-1:0] buf_q, buf_nxt, tmp_q;
  logic arm, tload;

  assign arm    = wr_valid && (wr_addr == AW'(ARM_IDX));
  assign tload  = (arm || pend) && ((iv == IV_OPEN) || crest_ev || trough_ev);
  assign cmp_ld = at_crest ? crest_ev : trough_ev;

  for (genvar g = 0; g < NV; g++) begin : g_slot
    assign buf_nxt[g] = (wr_valid && (wr_addr == AW'(g))) ? wr_data : buf_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q[g] <= rst_val(g);
        tmp_q[g] <= rst_val(g);
        cmp_q[g] <= rst_val(g);
      end else begin
        buf_q[g] <= buf_nxt[g];
        if (tload)  tmp_q[g] <= buf_nxt[g];
        if (cmp_ld) cmp_q[g] <= tmp_q[g];
      end
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_tmp_out
    assign tmp_duty[g] = tmp_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (arm || pend) && !tload;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NV; i++) begin
      if (rd_addr == AW'(i))            rd_data = buf_q[i];
      if (rd_addr == AW'(CMP_BASE + i)) rd_data = cmp_q[i];
    end
  end
endmodule

// File: rtl/cpwm_phase.sv
`timescale 1ns/1ps
module cpwm_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ct,
  input  logic          up,
  input  logic [CW-1:0] duty_act,
  input  logic [CW-1:0] duty_new,
  input  logic          dual,
  input  logic [CW-1:0] dead,
  input  logic          lvl_p,
  input  logic          lvl_n,
  output logic          pwm_p,
  output logic          pwm_n
);
  logic          st, st_nxt, hit, drv_p, drv_n;
  logic [CW-1:0] dtc;

  assign hit    = (ct == duty_act) || (dual && (ct == duty_new));
  assign st_nxt = hit ? up : st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= 1'b0;
      dtc <= '0;
    end else begin
      st <= st_nxt;
      if (st_nxt != st)   dtc <= dead;
      else if (dtc != '0) dtc <= dtc - 1'b1;
    end
  end

  assign drv_p = st && (dtc == '0);
  assign drv_n = !st && (dtc == '0);
  assign pwm_p = lvl_p ? drv_p : !drv_p;
  assign pwm_n = lvl_n ? drv_n : !drv_n;
endmodule

// File: rtl/cpwm_staged_update.sv
`timescale 1ns/1ps
module cpwm_staged_update
  import cpwm_pkg::*;
#(
  parameter int CW       = 16,
  parameter int AW       = 4,
  parameter int RST_PEAK = 100,
  parameter int RST_DEAD = 4,
  parameter int RST_DUTY = 50
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  input  logic           xfer_at_crest,
  input  logic           lvl_p,
  input  logic           lvl_n,
  output logic [2:0]     pwm_p,
  output logic [2:0]     pwm_n,
  output logic [1:0]     ival,
  output logic           xfer_pend
);
  localparam int NV       = NPH + 2;
  localparam int IDX_PEAK = NPH;
  localparam int IDX_DEAD = NPH + 1;

  logic [NPH-1:0][CW-1:0] tmp_duty;
  logic [NV-1:0][CW-1:0]  cmp_q;
  logic [CW-1:0]          ct;
  logic                   up, crest_ev, trough_ev, cmp_ld, dual;
  ival_e                  iv;

  assign wr_ready = 1'b1;

  cpwm_carrier #(.CW(CW)) u_carrier (
    .clk(clk), .rst_n(rst_n),
    .peak(cmp_q[IDX_PEAK]), .dead(cmp_q[IDX_DEAD]),
    .ct(ct), .up(up), .iv(iv),
    .crest_ev(crest_ev), .trough_ev(trough_ev)
  );

  cpwm_stage #(
    .CW(CW), .AW(AW), .RST_PEAK(RST_PEAK), .RST_DEAD(RST_DEAD), .RST_DUTY(RST_DUTY)
  ) u_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .iv(iv), .crest_ev(crest_ev), .trough_ev(trough_ev), .at_crest(xfer_at_crest),
    .tmp_duty(tmp_duty), .cmp_q(cmp_q), .pend(xfer_pend), .cmp_ld(cmp_ld)
  );

  assign dual = xfer_at_crest ? (iv == IV_PRE_TROUGH) : (iv == IV_PRE_CREST);

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    cpwm_phase #(.CW(CW)) u_phase (
      .clk(clk), .rst_n(rst_n),
      .ct(ct), .up(up),
      .duty_act(cmp_q[g]), .duty_new(tmp_duty[g]), .dual(dual),
      .dead(cmp_q[IDX_DEAD]),
      .lvl_p(lvl_p), .lvl_n(lvl_n),
      .pwm_p(pwm_p[g]), .pwm_n(pwm_n[g])
    );
  end

  assign ival = iv;
endmodule

// File: rtl/cpwm_chk.sv
`timescale 1ns/1ps
module cpwm_chk #(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int NV = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [AW-1:0]    wr_addr,
  input logic [1:0]       ival,
  input logic             xfer_pend,
  input logic [2:0]       pwm_p,
  input logic [2:0]       pwm_n,
  input logic             lvl_p,
  input logic             lvl_n,
  input logic             cmp_ld,
  input logic [NV*CW-1:0] cmp_flat
);
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    ival != 2'd3);

  a_r4_no_pend_in_open: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_pend && ival == 2'd0));

  a_r3_open_arm_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == AW'(2) && ival == 2'd0) |=> !xfer_pend);

  a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ld |=> $stable(cmp_flat));

  for (genvar g = 0; g < 3; g++) begin : g_ovl
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !((pwm_p[g] == lvl_p) && (pwm_n[g] == lvl_n)));
  end
endmodule

bind cpwm_staged_update cpwm_chk #(.CW(CW), .AW(AW), .NV(NV)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .ival(ival), .xfer_pend(xfer_pend), .pwm_p(pwm_p), .pwm_n(pwm_n),
  .lvl_p(lvl_p), .lvl_n(lvl_n), .cmp_ld(cmp_ld), .cmp_flat(cmp_q)
);

// File: tb/tb_cpwm_staged_update.sv
`timescale 1ns/1ps
module tb_cpwm_staged_update;
  localparam int CW = 8, AW = 4, P0 = 20, D0 = 3, DU0 = 10;
  localparam int NTV = 6;
  // {write addr, write data, read addr, expected read}
  localparam int TV [NTV][4] = '{
    '{0, 7, 0, 7}, '{1, 9, 1, 9}, '{3, 22, 3, 22},
    '{4, 4, 4, 4}, '{6, 55, 6, 0}, '{0, 12, 0, 12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [CW-1:0] wr_data = '0, rd_data;
  logic xfer_at_crest = 1'b0, lvl_p = 1'b1, lvl_n = 1'b1;
  logic [2:0] pwm_p, pwm_n;
  logic [1:0] ival;
  logic xfer_pend;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cpwm_staged_update #(.CW(CW), .AW(AW), .RST_PEAK(P0), .RST_DEAD(D0), .RST_DUTY(DU0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .xfer_at_crest(xfer_at_crest), .lvl_p(lvl_p), .lvl_n(lvl_n),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .ival(ival), .xfer_pend(xfer_pend)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a);
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic wr(input int a, input int d);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_iv(input int v);
    while (int'(ival) != v) @(negedge clk);
  endtask

  task automatic enter_iv(input int v);
    while (int'(ival) == v) @(negedge clk);
    wait_iv(v);
  endtask

  task automatic iv_run(input int v, output int n);
    enter_iv(v);
    n = 0;
    while (int'(ival) == v) begin n++; @(negedge clk); end
  endtask

  task automatic period(output int n);
    enter_iv(1);
    n = 0;
    do begin n++; @(negedge clk); end while (int'(ival) == 1);
    while (int'(ival) != 1) begin n++; @(negedge clk); end
  endtask

  task automatic pin_run(input int ph, input bit pos, input bit lvl, output int n);
    while (((pos ? pwm_p[ph] : pwm_n[ph])) == lvl) @(negedge clk);
    while (((pos ? pwm_p[ph] : pwm_n[ph])) != lvl) @(negedge clk);
    n = 0;
    while (((pos ? pwm_p[ph] : pwm_n[ph])) == lvl) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, n, ovl;
    repeat (3) @(negedge clk);
    // reset state
    chk("R2 reset pend", int'(xfer_pend), 0);
    chk("R6 reset ival", int'(ival), 0);
    chk("R8 reset neg side driven", int'(pwm_n), 7);
    chk("R8 reset pos side idle", int'(pwm_p), 0);
    rd(0, v);  chk("R1 reset duty buffer", v, DU0);
    rd(11, v); chk("R5 reset active peak", v, P0);
    rd(12, v); chk("R5 reset active dead", v, D0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: table of plain buffer writes, none arms or reaches the active stage
    for (int i = 0; i < NTV; i++) begin
      chk("R1 ready", int'(wr_ready), 1);
      wr(TV[i][0], TV[i][1]);
      rd(TV[i][2], v); chk("R1 buffer readback", v, TV[i][3]);
      chk("R1 no arm", int'(xfer_pend), 0);
      rd(8, v);  chk("R1 active duty untouched", v, DU0);
      rd(11, v); chk("R1 active peak untouched", v, P0);
    end

    // R6: interval widths with P=20, D=3
    iv_run(1, n); chk("R6 pre-crest width", n, D0 + 1);
    iv_run(2, n); chk("R6 pre-trough width", n, D0 + 1);
    period(n);    chk("R6 carrier period", n, 2 * P0);

    // R3 + R5 trough: arm in open interval while counting up
    enter_iv(2); wait_iv(0);
    wr(2, 11);
    chk("R3 open arm no pend", int'(xfer_pend), 0);
    rd(10, v); chk("R5 active unchanged before trough", v, DU0);
    wait_iv(2);
    rd(8, v); chk("R5 active unchanged in pre-trough", v, DU0);
    wait_iv(0);
    rd(8, v);  chk("R3 duty0 active", v, 12);
    rd(9, v);  chk("R3 duty1 active", v, 9);
    rd(10, v); chk("R3 duty2 active", v, 11);
    rd(11, v); chk("R3 peak active", v, 22);
    rd(12, v); chk("R3 dead active", v, 4);

    // R6 again with P=22, D=4
    iv_run(1, n); chk("R6 pre-crest width new", n, 5);
    period(n);    chk("R6 carrier period new", n, 44);

    // R4 + R11: arm inside the pre-crest window, then a further write
    enter_iv(1);
    wr_valid = 1'b1; wr_addr = 4'd2; wr_data = 8'd13;
    @(negedge clk);
    wr_addr = 4'd1; wr_data = 8'd14;
    chk("R4 pend rises in window", int'(xfer_pend), 1);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R4 pend holds in window", int'(xfer_pend), 1);
    chk("R4 still in window", int'(ival), 1);
    wait_iv(0);
    chk("R4 pend clears at window end", int'(xfer_pend), 0);
    enter_iv(2); wait_iv(0);
    rd(9, v);  chk("R11 late write carried", v, 14);
    rd(10, v); chk("R4 deferred duty2 active", v, 13);

    // R5 crest mode
    xfer_at_crest = 1'b1;
    enter_iv(2); wait_iv(0);
    wr(2, 16);
    wait_iv(1);
    rd(10, v); chk("R5 crest mode unchanged before crest", v, 13);
    wait_iv(0);
    rd(10, v); chk("R5 crest mode active after crest", v, 16);

    // R8: phase 2 duty 16, P=22, D=4
    pin_run(2, 1'b1, 1'b1, n); chk("R8 pos width", n, 8);
    pin_run(2, 1'b0, 1'b1, n); chk("R8 neg width", n, 28);
    ovl = 0;
    for (int i = 0; i < 50; i++) begin
      for (int p = 0; p < 3; p++) if (pwm_p[p] == lvl_p && pwm_n[p] == lvl_n) ovl++;
      @(negedge clk);
    end
    chk("R10 no overlap", ovl, 0);

    // R9: active-low positive side
    lvl_p = 1'b0;
    @(negedge clk);
    pin_run(2, 1'b1, 1'b0, n); chk("R9 active-low pos width", n, 8);
    lvl_p = 1'b1;

    // R7: dual compare in the pre-crest window (trough mode)
    xfer_at_crest = 1'b0;
    enter_iv(2); wait_iv(0);
    wr(0, 30); wr(2, 16);
    enter_iv(2); wait_iv(0);
    rd(8, v); chk("R7 setup active duty0", v, 30);
    wr(0, 20); wr(2, 16);
    wait_iv(1);
    chk("R7 pos idle before window", int'(pwm_p[0]), 0);
    wait_iv(0);
    repeat (3) @(negedge clk);
    chk("R7 new duty acts in window", int'(pwm_p[0]), 1);
    chk("R7 still open interval", int'(ival), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule